// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the interrupt half of an SMBus peripheral. It keeps a small set of latched over-limit status flags, a configuration mask bit and an alert-mode bit. It pulls a shared, active-low open-drain ALERT line whenever a flag is set and the mask is clear.

When a host sees ALERT low, it reads from the broadcast alert response address. If this device is alerting and its mode bit allows it, the block acknowledges. It then shifts out its own address byte on SDA against any other alerting devices, using wired-AND arbitration in which the numerically lowest address wins. A device that loses arbitration falls silent and keeps ALERT low for a later round. The winner releases ALERT by setting its own mask bit.

Register reads and writes reach the block through plain single-cycle strobes from a separate register-access slave. No data stream crosses the block edge, so all pins are plain control and status pins with no valid/ready handshake and no back-pressure. The bus lines enter raw and are synchronised inside the block.

Top module: `smb_alert_resp`

## Requirements
- R1: After reset, status, mask and mode read as 0, and both `alert_pull` and `sda_pull` are 0 (lines released).
- R2: A 1 on `evt_set[i]` sets status bit i, for example the remote-high flag at bit 4. The bit holds until a read-clear. If an event and `stat_rd_clr` occur in the same cycle, the new event bit survives.
- R3: `alert_pull` is 1 (ALERT driven low) exactly when some status bit is 1 and the mask bit is 0.
- R4: The address byte 0x19 is recognised as the 7-bit address 0001100 followed by a read bit of 1. When it arrives while `alert_pull` is 1 and the mode bit is 0, the block pulls SDA low for the ninth clock. It then sends {DEV_ADDR, 1'b1}, most significant bit first, pulling SDA low for each 0 bit.
- R5: With mode bit 0 set to 1, the response address gets no acknowledge, and SDA stays released for the whole transfer.
- R6: If the block is not alerting, or the address byte is anything other than 0x19, it does not acknowledge. It leaves SDA released through the data phase, so a lone host reads 0xFF.
- R7: If the block sends a 1 and samples SDA as 0 on a rising SCL edge, it releases SDA for the rest of the byte. The mask and ALERT are left unchanged.
- R8: Once the eighth data bit has been sampled without a loss, the mask bit becomes 1, so ALERT is released. The bus sync adds a fixed delay of three clocks from the SCL rise.
- R9: After a read-clear, a host write that returns the mask to 0 brings ALERT back only if a status bit has been set again.
- R10: A START or STOP at any point releases SDA and restarts the protocol. Status, mask and mode are not changed.
- R11: A config write loads the mask from bit 7 of `cfg_wdata`, and a mode write loads the mode from bit 0 of `mode_wdata`. The read ports return the mask at bit 7 and the mode at bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low |
| alert_pull | output | 1 | 1 pulls ALERT low |
| evt_set | input | STAT_W | One-cycle over-limit event per status bit |
| stat_rd_clr | input | 1 | Host read of status; clears the flags |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_wdata | input | 8 | Config write data (mask at bit 7) |
| mode_wr | input | 1 | Alert-mode register write strobe |
| mode_wdata | input | 8 | Mode write data (mode at bit 0) |
| stat_rdata | output | STAT_W | Latched status flags |
| cfg_rdata | output | 8 | Config read value |
| mode_rdata | output | 8 | Mode read value |

## Verification
The bench builds the block with DEV_ADDR = 7'h2A and a second bench-modelled device at 7'h28. The two address bytes (0x55 and 0x51) first differ at the sixth bit sent, so the losing path is exercised in the middle of a byte rather than at its first bit. It also checks that SDA stays released for the bits that follow the loss. The address value 0x2A also mixes 0 and 1 bits, so each data bit tests both driving SDA low and leaving it released. STAT_W stays at 8, which places the remote-high flag at bit 4.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  // Broadcast alert response address, read direction
  localparam logic [6:0] RESP_ADDR7 = 7'b0001100;
  localparam logic [7:0] RESP_RD_BYTE = {RESP_ADDR7, 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_DATA,
    ST_TAIL,
    ST_SKIP
  } resp_state_e;
endpackage

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/smb_alert_cond.sv
module smb_alert_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_alert_regs.sv
module smb_alert_regs #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              stat_rd_clr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  input  logic              win_pulse,
  output logic [STAT_W-1:0] status_q,
  output logic              mask_q,
  output logic              mode_q,
  output logic              alert_act
);
  localparam int MASK_BIT = 7;
  localparam int MODE_BIT = 0;

  logic [STAT_W-1:0] status_base;
  logic unused_wbits;

  assign unused_wbits = ^{cfg_wdata[MASK_BIT-1:0], mode_wdata[7:MODE_BIT+1]};
  assign status_base  = stat_rd_clr ? '0 : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      status_q <= status_base | evt_set;
      if (cfg_wr)         mask_q <= cfg_wdata[MASK_BIT];
      else if (win_pulse) mask_q <= 1'b1;
      if (mode_wr)        mode_q <= mode_wdata[MODE_BIT];
    end
  end

  assign alert_act = (|status_q) & ~mask_q;

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((status_q & $past(evt_set)) == $past(evt_set)));
  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && evt_set == '0) |=> (status_q == '0));
  a_r8_win_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pulse && !cfg_wr) |=> mask_q);
  a_r11_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == $past(mode_wdata[MODE_BIT])));
endmodule

// File: rtl/smb_alert_fsm.sv
module smb_alert_fsm
  import smb_alert_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_c,
  input  logic stop_c,
  input  logic sda_s,
  input  logic alert_act,
  input  logic mode_q,
  output logic sda_drv,
  output logic win_pulse
);
  localparam logic [7:0] TX_BYTE = {DEV_ADDR, 1'b1};
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);

  resp_state_e state;
  logic [CNT_W-1:0] bitcnt;
  logic [6:0] rx;
  logic [7:0] tx;
  logic lose_now;

  assign lose_now  = (state == ST_DATA) && scl_rise && tx[7] && !sda_s;
  assign win_pulse = (state == ST_DATA) && scl_rise && (bitcnt == LAST_BIT) && !lose_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx      <= '0;
      tx      <= '1;
      sda_drv <= 1'b0;
    end else if (start_c) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      sda_drv <= 1'b0;
    end else if (stop_c) begin
      state   <= ST_IDLE;
      sda_drv <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: if (scl_rise) begin
          rx     <= {rx[5:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            if ({rx, sda_s} == RESP_RD_BYTE && alert_act && !mode_q) state <= ST_ACK_WAIT;
            else                                                       state <= ST_SKIP;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_drv <= 1'b1;
          state   <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          tx      <= TX_BYTE;
          sda_drv <= ~TX_BYTE[7];
          bitcnt  <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (scl_rise) begin
            if (lose_now) begin
              sda_drv <= 1'b0;
              state   <= ST_SKIP;
            end else if (bitcnt == LAST_BIT) begin
              state <= ST_TAIL;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else if (scl_fall) begin
            tx      <= {tx[6:0], 1'b1};
            sda_drv <= ~tx[6];
          end
        end
        ST_TAIL: if (scl_fall) begin
          sda_drv <= 1'b0;
          state   <= ST_SKIP;
        end
        ST_SKIP: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_loss_release: assert property (@(posedge clk) disable iff (!rst_n)
    lose_now |=> !sda_drv);
  a_r10_cond_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_drv);
  a_r5_mode_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && mode_q && !start_c && !stop_c) |=> (state != ST_ACK_WAIT));
  a_r6_quiet_no_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && !alert_act && !start_c && !stop_c) |=> (state != ST_ACK_WAIT));
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int STAT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic              alert_pull,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              stat_rd_clr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic [7:0]        cfg_rdata,
  output logic [7:0]        mode_rdata
);
  logic [1:0] bus_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic mask_q, mode_q, alert_act, win_pulse;

  smb_alert_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  smb_alert_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  smb_alert_regs #(.STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .stat_rd_clr(stat_rd_clr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .win_pulse(win_pulse), .status_q(stat_rdata), .mask_q(mask_q), .mode_q(mode_q),
    .alert_act(alert_act)
  );

  smb_alert_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(bus_s[0]), .alert_act(alert_act),
    .mode_q(mode_q), .sda_drv(sda_pull), .win_pulse(win_pulse)
  );

  assign alert_pull = alert_act;
  assign cfg_rdata  = {mask_q, 7'b0};
  assign mode_rdata = {7'b0, mode_q};
endmodule

// File: tb/tb_smb_alert_resp.sv
module tb_smb_alert_resp;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [6:0] OTH = 7'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, o_low = 1'b0;
  logic [7:0] evt_set = '0, cfg_wdata = '0, mode_wdata = '0;
  logic stat_rd_clr = 1'b0, cfg_wr = 1'b0, mode_wr = 1'b0;
  logic sda_pull, alert_pull;
  logic [7:0] stat_rdata, cfg_rdata, mode_rdata;
  logic sda_line;

  assign sda_line = ~(m_low | o_low | sda_pull);

  smb_alert_resp #(.DEV_ADDR(DEV), .STAT_W(8), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull(sda_pull),
    .alert_pull(alert_pull), .evt_set(evt_set), .stat_rd_clr(stat_rd_clr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .stat_rdata(stat_rdata), .cfg_rdata(cfg_rdata), .mode_rdata(mode_rdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int win_at = -1;
  bit finished = 0;
  logic [7:0] m_status = '0;
  logic m_mask = 1'b0, m_mode = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model of the register side
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_status <= '0; m_mask <= 1'b0; m_mode <= 1'b0;
    end else begin
      m_status <= (stat_rd_clr ? 8'h00 : m_status) | evt_set;
      if (cfg_wr) m_mask <= cfg_wdata[7];
      else if (cyc == win_at) m_mask <= 1'b1;
      if (mode_wr) m_mode <= mode_wdata[0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 status", stat_rdata, m_status);
      chk("R3 alert", alert_pull, (|m_status) & ~m_mask);
      chk("R8 mask", cfg_rdata, {m_mask, 7'b0});
      chk("R11 mode", mode_rdata, {7'b0, m_mode});
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] v, input logic clr);
    evt_set = v; stat_rd_clr = clr; wclk(1); evt_set = '0; stat_rd_clr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_wr = 1'b1; wclk(1); cfg_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_wdata = v; mode_wr = 1'b1; wclk(1); mode_wr = 1'b0;
  endtask

  task automatic bus_start();
    scl = 1'b1; m_low = 1'b0; o_low = 1'b0; wclk(8);
    m_low = 1'b1; wclk(8);
    scl = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; o_low = 1'b0; wclk(4);
    scl = 1'b1; wclk(4);
    m_low = 1'b0; wclk(8);
  endtask

  task automatic clk_bit(input logic mlo, input logic olo, input bit arm,
                         output logic line, output logic oe);
    m_low = mlo; o_low = olo; wclk(4);
    scl = 1'b1;
    if (arm) win_at = cyc + 2;
    wclk(4);
    line = sda_line; oe = sda_pull;
    wclk(4);
    scl = 1'b0; wclk(4);
  endtask

  task automatic resp_round(input logic [7:0] abyte, input bit oth_act, input string req);
    logic line, oe;
    logic [7:0] rd, dbyte, obyte;
    bit dut_act, d_lost, o_lost;
    logic dbit, obit, bus;
    dut_act = (abyte == 8'h19) && (|m_status) && !m_mask && !m_mode;
    dbyte = {DEV, 1'b1}; obyte = {OTH, 1'b1};
    d_lost = 0; o_lost = 0; rd = '0;
    bus_start();
    for (int i = 7; i >= 0; i--) clk_bit(!abyte[i], 1'b0, 1'b0, line, oe);
    clk_bit(1'b0, oth_act, 1'b0, line, oe);
    chk({req, " ack"}, oe, dut_act);
    for (int i = 7; i >= 0; i--) begin
      dbit = (dut_act && !d_lost) ? dbyte[i] : 1'b1;
      obit = (oth_act && !o_lost) ? obyte[i] : 1'b1;
      bus = dbit & obit;
      clk_bit(1'b0, !obit, dut_act && !d_lost && bus == dbit && i == 0, line, oe);
      chk({req, " data drive"}, oe, dut_act && !d_lost && !dbyte[i]);
      chk({req, " data line"}, line, bus);
      rd[i] = line;
      if (dbit && !bus) d_lost = 1;
      if (obit && !bus) o_lost = 1;
    end
    clk_bit(1'b0, 1'b0, 1'b0, line, oe);
    chk({req, " nack release"}, oe, 1'b0);
    bus_stop();
    chk({req, " byte"}, rd,
        dut_act ? (oth_act ? 8'h51 : 8'h55) : (oth_act ? 8'h51 : 8'hFF));
  endtask

  initial begin
    logic line, oe;
    wclk(3);
    chk("R1 alert", alert_pull, 1'b0);
    chk("R1 sda", sda_pull, 1'b0);
    rst_n = 1'b1;
    wclk(2);
    chk("R1 status", stat_rdata, 8'h00);
    chk("R1 cfg", cfg_rdata, 8'h00);
    chk("R1 mode", mode_rdata, 8'h00);

    // R11: only bit 7 / bit 0 matter
    wr_cfg(8'h7F); wclk(1);
    chk("R11 cfg low bits ignored", cfg_rdata, 8'h00);
    wr_mode(8'hFE); wclk(1);
    chk("R11 mode high bits ignored", mode_rdata, 8'h00);

    // R6: nobody alerting -> 0xFF
    resp_round(8'h19, 1'b0, "R6 idle");

    // R2, R3: remote-high flag
    pulse_evt(8'h10, 1'b0); wclk(1);
    chk("R2 bit4 set", stat_rdata, 8'h10);
    chk("R3 alert low", alert_pull, 1'b1);

    // R5: mode bit blocks the reply
    wr_mode(8'h01);
    resp_round(8'h19, 1'b0, "R5 mode");
    wr_mode(8'h00);

    // R6: other address while alerting
    resp_round(8'h99, 1'b0, "R6 other addr");

    // R7: lose to lower address mid-byte
    resp_round(8'h19, 1'b1, "R7 loss");
    chk("R7 alert kept", alert_pull, 1'b1);

    // R10: abort after four address bits
    bus_start();
    for (int i = 7; i >= 4; i--) clk_bit(!(8'h19 >> i & 8'h01), 1'b0, 1'b0, line, oe);
    bus_stop();
    chk("R10 released", sda_pull, 1'b0);
    chk("R10 status kept", stat_rdata, 8'h10);
    // R10: repeated start in the middle of an address
    bus_start();
    for (int i = 7; i >= 5; i--) clk_bit(1'b1, 1'b0, 1'b0, line, oe);
    resp_round(8'h19, 1'b0, "R4 R8 win");
    chk("R8 alert released", alert_pull, 1'b0);
    chk("R8 mask set", cfg_rdata, 8'h80);

    // R6: masked, so not alerting
    resp_round(8'h19, 1'b0, "R6 masked");

    // R9 / R2 clear ordering
    pulse_evt(8'h01, 1'b0); wclk(1);
    chk("R3 masked quiet", alert_pull, 1'b0);
    pulse_evt(8'h00, 1'b1); wclk(1);
    chk("R9 cleared", stat_rdata, 8'h00);
    pulse_evt(8'h02, 1'b1); wclk(1);
    chk("R2 set beats clear", stat_rdata, 8'h02);
    pulse_evt(8'h00, 1'b1);
    wr_cfg(8'h80 ^ 8'hFF); wclk(1);
    chk("R9 unmask no status", alert_pull, 1'b0);
    pulse_evt(8'h08, 1'b0); wclk(1);
    chk("R9 realert", alert_pull, 1'b1);
    wclk(4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule